// File: doc/BRIEF.md
# Hash Message Padding Unit

This unit sits between a byte-aligned message source and a compression core for a hash that works on 512-bit blocks. Message words arrive as 64-bit beats with a valid/ready handshake. The final beat carries a last flag and a count of its valid bytes. The unit forwards message words unchanged and closes the message with a marker byte 0x80. It then adds zero fill and writes the number of padded blocks into the final 64-bit word of the last block. The output is a 64-bit word stream, eight words per block, with a flag on the first word of each block.

The length word does not hold the bit length of the message. It holds the count of padded blocks, including any block that the padding itself adds. After the padded message the unit sends one more block of eight zero words, with a flag set. This lets the downstream core run its output transformation as one more compression pass through the same permutation. While the unit produces padding or the zero block, it refuses input. The next message can start in the cycle after the last zero word.

Bytes are big-endian inside a word: byte 0 of a word travels in bits [63:56] and byte 7 in bits [7:0].

Top module: `msg_pad_unit`

## Requirements
- R1: While message words are being accepted, `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and every word that is not flagged last appears unchanged on `out_data`.
- R2: A last word with n valid bytes (0 ≤ n ≤ 7) is sent with bytes 0..n-1 kept, byte n set to 0x80 and every later byte zero, whatever the input held there.
- R3: When the last word has 8 valid bytes, it passes unchanged, and the next generated word is 0x80 in byte 0 with all other bytes zero.
- R4: Zero words fill the last padded block up to its word 6. Word 7 of that block is the number of padded blocks as a 64-bit big-endian value.
- R5: When fewer than 9 bytes of the current block remain after the message, the marker or the length spills into one extra block. The block count includes that block.
- R6: An empty message (a last word with 0 valid bytes as the first word) produces exactly one block: 0x80 in byte 0 of word 0, zeros, and a count of 1 in word 7.
- R7: The length word is followed by eight all-zero words with `out_zero_blk` high. `out_zero_blk` is low on every other word.
- R8: `out_sob` is high exactly on word 0 of every block, including the zero block. `out_msg_end` is high only on the length word.
- R9: `in_ready` is low from the acceptance of the last message word until the last zero word has been transferred.
- R10: A generated word held with `out_ready` low stays valid and unchanged until it is taken.
- R11: Each message starts a fresh block count and word position, so back-to-back messages are padded independently.
- R12: After reset, with no input offered, `out_valid` is low and `in_ready` equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message word offered |
| in_ready | output | 1 | Message word accepted this cycle when valid |
| in_data | input | 64 | Message word, byte 0 in bits [63:56] |
| in_last | input | 1 | Word is the final message word |
| in_nbytes | input | 4 | Valid bytes in the final word, 0 to 8 |
| out_valid | output | 1 | Padded word offered |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 64 | Padded stream word |
| out_sob | output | 1 | Word 0 of a block |
| out_msg_end | output | 1 | Length word closing the padded message |
| out_zero_blk | output | 1 | Word belongs to the trailing zero block |

## Verification
The hardest situation to reach is a spill: the padding crosses into a further block. This happens when the last word lands in word 6 with all eight bytes valid, or in word 7 with any byte count. The directed tests pick message lengths of 55, 56, 60 and 64 bytes so that the marker falls exactly on each side of the nine-free-byte limit. A long message is also sent under irregular backpressure while the bench keeps offering a further word during the padding phase. This exposes any early acceptance and any change to a stalled generated word.

// File: rtl/msg_pad_pkg.sv
package msg_pad_pkg;

    localparam int WORD_BYTES = 8;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int BLK_WORDS  = 8;
    localparam int IDX_W      = $clog2(BLK_WORDS);
    localparam int CNT_W      = 64;
    localparam int NB_W       = $clog2(WORD_BYTES + 1);
    localparam logic [7:0] MARK_BYTE = 8'h80;

    typedef enum logic [1:0] {
        ST_MSG,
        ST_PAD,
        ST_ZERO
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_PASS,
        SRC_TAIL,
        SRC_MARK,
        SRC_FILL,
        SRC_COUNT
    } word_src_e;

    typedef struct packed {
        logic sob;
        logic msg_end;
        logic zero_blk;
    } out_tags_t;

    // keep the first n bytes, place the marker at byte n, clear the rest
    function automatic logic [WORD_W-1:0] tail_word(input logic [WORD_W-1:0] d,
                                                    input logic [NB_W-1:0]   n);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (i < int'(n))
                r[WORD_W-1-8*i -: 8] = d[WORD_W-1-8*i -: 8];
            else if (i == int'(n))
                r[WORD_W-1-8*i -: 8] = MARK_BYTE;
        end
        return r;
    endfunction

endpackage

// File: rtl/msg_pad_seq.sv
module msg_pad_seq
    import msg_pad_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [NB_W-1:0]  in_nbytes,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output word_src_e        src,
    output out_tags_t        tags,
    output logic             gen,
    output logic [CNT_W-1:0] blk_cnt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_WORDS - 1);

    seq_state_e       st_q;
    logic [IDX_W-1:0] widx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mark_q;
    logic             xfer;

    always_comb begin
        in_ready      = 1'b0;
        out_valid     = 1'b0;
        src           = SRC_FILL;
        tags          = '0;
        tags.sob      = (widx_q == '0);
        case (st_q)
            ST_MSG: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                src       = in_last ? SRC_TAIL : SRC_PASS;
            end
            ST_PAD: begin
                out_valid = 1'b1;
                if (widx_q == LAST_IDX && mark_q) begin
                    src          = SRC_COUNT;
                    tags.msg_end = 1'b1;
                end else if (!mark_q) begin
                    src = SRC_MARK;
                end else begin
                    src = SRC_FILL;
                end
            end
            ST_ZERO: begin
                out_valid     = 1'b1;
                src           = SRC_FILL;
                tags.zero_blk = 1'b1;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    assign xfer    = out_valid && out_ready;
    assign gen     = (st_q != ST_MSG);
    assign blk_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_MSG;
            widx_q <= '0;
            cnt_q  <= '0;
            mark_q <= 1'b0;
        end else if (xfer) begin
            widx_q <= widx_q + IDX_W'(1);
            if (st_q != ST_ZERO && widx_q == '0)
                cnt_q <= cnt_q + CNT_W'(1);
            case (st_q)
                ST_MSG: begin
                    if (in_last) begin
                        st_q   <= ST_PAD;
                        mark_q <= (in_nbytes < NB_W'(WORD_BYTES));
                    end
                end
                ST_PAD: begin
                    if (src == SRC_COUNT)
                        st_q <= ST_ZERO;
                    else if (src == SRC_MARK)
                        mark_q <= 1'b1;
                end
                ST_ZERO: begin
                    if (widx_q == LAST_IDX) begin
                        st_q  <= ST_MSG;
                        cnt_q <= '0;
                    end
                end
                default: st_q <= ST_MSG;
            endcase
        end
    end

    AST_ZERO_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        $fell(tags.zero_blk) |-> $past(widx_q) == LAST_IDX && tags.sob) // R7
        else $error("zero block left before its last word");

    AST_COUNT_FROM_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
        (tags.msg_end && out_valid) |-> cnt_q != '0) // R4
        else $error("length word with zero block count");

endmodule

// File: rtl/msg_pad_fmt.sv
module msg_pad_fmt
    import msg_pad_pkg::*;
(
    input  word_src_e         src,
    input  logic [WORD_W-1:0] in_data,
    input  logic [NB_W-1:0]   in_nbytes,
    input  logic [CNT_W-1:0]  blk_cnt,
    output logic [WORD_W-1:0] word
);

    always_comb begin
        case (src)
            SRC_PASS:  word = in_data;
            SRC_TAIL:  word = tail_word(in_data, in_nbytes);
            SRC_MARK:  word = {MARK_BYTE, {(WORD_W-8){1'b0}}};
            SRC_COUNT: word = WORD_W'(blk_cnt);
            default:   word = '0;
        endcase
    end

endmodule

// File: rtl/msg_pad_unit.sv
module msg_pad_unit
    import msg_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    input  logic [NB_W-1:0]   in_nbytes,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sob,
    output logic              out_msg_end,
    output logic              out_zero_blk
);

    word_src_e        src;
    out_tags_t        tags;
    logic             gen;
    logic [CNT_W-1:0] blk_cnt;

    msg_pad_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_nbytes (in_nbytes),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .src       (src),
        .tags      (tags),
        .gen       (gen),
        .blk_cnt   (blk_cnt)
    );

    msg_pad_fmt u_fmt (
        .src       (src),
        .in_data   (in_data),
        .in_nbytes (in_nbytes),
        .blk_cnt   (blk_cnt),
        .word      (out_data)
    );

    assign out_sob      = tags.sob;
    assign out_msg_end  = tags.msg_end;
    assign out_zero_blk = tags.zero_blk;

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
        (gen && out_valid && !out_ready) |=> out_valid && $stable(out_data)) // R10
        else $error("generated word changed under backpressure");

    AST_ZERO_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_msg_end) |=> out_zero_blk && out_sob) // R7
        else $error("zero block did not follow length word");

    AST_ZERO_WORDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_zero_blk) |-> out_data == '0) // R7
        else $error("zero block word not clear");

    AST_NO_ACCEPT_WHILE_PADDING: assert property (@(posedge clk) disable iff (rst)
        (out_zero_blk || out_msg_end) |-> !in_ready) // R9
        else $error("input accepted during padding");

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_msg_end) |-> out_data != '0) // R4
        else $error("length word is zero");

endmodule

// File: tb/msg_pad_unit_bench.sv
module msg_pad_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_data;
    logic        in_last;
    logic [3:0]  in_nbytes;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_data;
    logic        out_sob;
    logic        out_msg_end;
    logic        out_zero_blk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [7:0] exp_b [0:1023];

    msg_pad_unit u_msg_pad_unit (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_last      (in_last),
        .in_nbytes    (in_nbytes),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_sob      (out_sob),
        .out_msg_end  (out_msg_end),
        .out_zero_blk (out_zero_blk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_LIMIT) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WDOG_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] msg_byte(input int i, input int seed);
        return 8'((i * 29 + seed * 13 + 7) & 255);
    endfunction

    function automatic logic [63:0] in_word(input int j, input int len, input int seed);
        logic [63:0] w;
        for (int k = 0; k < 8; k++)
            w[63-8*k -: 8] = (8*j + k < len) ? msg_byte(8*j + k, seed) : 8'hA5;
        return w;
    endfunction

    // tag names the requirement the scenario targets
    task automatic run_msg(input int len, input int seed, input bit bp,
                           input bit extra, input string tag);
        int nw, nblk, nout, ii, oo, step;
        bit prev_stall;
        logic [63:0] prev_data, ew;
        nw   = (len == 0) ? 1 : (len + 7) / 8;
        nblk = (len + 9 + 63) / 64;
        nout = nblk * 8 + 8;
        for (int i = 0; i < nout * 8; i++)
            exp_b[i] = (i < len) ? msg_byte(i, seed) : ((i == len) ? 8'h80 : 8'h00);
        for (int k = 0; k < 8; k++)
            exp_b[nblk*64 - 8 + k] = 8'((64'(nblk)) >> (8 * (7 - k)));
        ii = 0; oo = 0; step = seed; prev_stall = 0; prev_data = '0;
        while (oo < nout) begin
            @(negedge clk);
            if (ii < nw) begin
                in_valid  = 1'b1;
                in_data   = in_word(ii, len, seed);
                in_last   = (ii == nw - 1);
                in_nbytes = (ii == nw - 1) ? 4'(len - 8 * ii) : 4'd8;
            end else if (extra) begin
                in_valid  = 1'b1;
                in_data   = '1;
                in_last   = 1'b0;
                in_nbytes = 4'd8;
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            out_ready = bp ? ((step % 3) != 0) : 1'b1;
            step++;
            #1;
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R10", "stalled word changed",
                    out_data, prev_data);
            if (ii < nw)
                chk(in_ready == out_ready && out_valid == in_valid, "R1",
                    "handshake not passed through", {62'd0, in_ready, out_valid},
                    {62'd0, out_ready, in_valid});
            else
                chk(!in_ready, "R9", "in_ready high while padding", 64'(in_ready), 64'd0);
            if (out_valid && out_ready) begin
                for (int k = 0; k < 8; k++) ew[63-8*k -: 8] = exp_b[oo*8 + k];
                chk(out_data == ew, tag, $sformatf("data word %0d", oo), out_data, ew);
                chk(out_sob == (oo % 8 == 0), "R8", $sformatf("sob word %0d", oo),
                    64'(out_sob), 64'(oo % 8 == 0));
                chk(out_msg_end == (oo == nblk*8 - 1), "R8",
                    $sformatf("msg_end word %0d", oo), 64'(out_msg_end),
                    64'(oo == nblk*8 - 1));
                chk(out_zero_blk == (oo >= nblk*8), "R7",
                    $sformatf("zero flag word %0d", oo), 64'(out_zero_blk),
                    64'(oo >= nblk*8));
                oo++;
            end
            if (in_valid && in_ready && ii < nw) ii++;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        #1;
        chk(!out_valid, "R12", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready, "R12", "in_ready after reset", 64'(in_ready), 64'd1);
    endtask

    task automatic t_short_tail();      run_msg(5,   1, 0, 0, "R2"); endtask
    task automatic t_full_last_word();  run_msg(16,  2, 0, 0, "R3"); endtask
    task automatic t_exact_fit();       run_msg(55,  3, 0, 0, "R4"); endtask
    task automatic t_spill_word6();     run_msg(56,  4, 0, 0, "R5"); endtask
    task automatic t_spill_word7();     run_msg(60,  5, 0, 0, "R5"); endtask
    task automatic t_spill_full_block(); run_msg(64, 6, 0, 0, "R5"); endtask
    task automatic t_empty();           run_msg(0,   7, 0, 0, "R6"); endtask
    task automatic t_long_backpressure(); run_msg(200, 8, 1, 1, "R10"); endtask
    task automatic t_back_to_back();
        run_msg(9,  9,  0, 0, "R11");
        run_msg(70, 10, 1, 0, "R11");
    endtask

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_data   = '0;
        in_last   = 1'b0;
        in_nbytes = '0;
        out_ready = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_short_tail();
        t_full_last_word();
        t_exact_fit();
        t_spill_word6();
        t_spill_word7();
        t_spill_full_block();
        t_empty();
        t_long_backpressure();
        t_back_to_back();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule